// File: doc/BRIEF.md
# Battery Reconnect and Supply Interlock Controller

This block drives the enable of a switch that joins the battery to the system rail. When no external input supply is present and the host holds its control line low, the battery is cut off so that standby leakage cannot drain it. To bring the battery back, the host must hold the control line high without a break for a programmed number of millisecond ticks. While the battery is joined, it stays joined for as long as the host keeps the line high.

An input-supply-valid flag overrides the host line. While the flag is set, the line has no effect and the connect output keeps the value it had. As soon as the flag clears, the line is honoured again on the next clock edge, with no extra delay. The control line is expected to come from a debouncer. A pad left floating must resolve to logic low before it reaches this block. The hold time is a parameter counted in tick pulses (default 2000 ticks of 1 ms), and the output comes straight from a register.

Top module: `batt_link_ctrl`

## Requirements
- R1: With supply_ok_i low and ctrl_i low at a clock edge, conn_o is 0 after that edge.
- R2: With supply_ok_i low and conn_o at 0, conn_o becomes 1 on the edge that samples the HOLD_TICKS-th tick_i pulse of an unbroken run of cycles with ctrl_i high. After fewer pulses it is still 0.
- R3: A cycle with ctrl_i low before the hold completes discards the progress made so far. A new full run of HOLD_TICKS pulses is then needed.
- R4: With conn_o at 1 and ctrl_i high, conn_o stays 1 whatever supply_ok_i and tick_i do.
- R5: While supply_ok_i is high, conn_o keeps its value regardless of ctrl_i and tick_i, and any hold progress is discarded.
- R6: On the first edge at which supply_ok_i is low again, ctrl_i takes effect with no added delay. A low line disconnects on that edge.
- R7: While rst_ni is low, conn_o is 0, and it stays 0 after reset until R2 is met.
- R8: Cycles with tick_i low add nothing to the hold. A line held high with no tick pulses never connects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 1 | Debounced host connect line; 1 requests connection |
| supply_ok_i | input | 1 | Input supply valid; 1 overrides the host line |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| conn_o | output | 1 | Battery switch enable, 1 joins the battery to the rail |

## Verification
The assertions assume that tick_i is a single-cycle pulse in the clock domain and that ctrl_i and supply_ok_i are already synchronous and free of glitches. The hold-window property counts pulses with its own counter, so it relies on tick_i never being stretched across cycles. The bench drives every input at the falling clock edge, keeps tick_i high for exactly one cycle per pulse, and sweeps run length and tick spacing around the HOLD_TICKS boundary on a small configuration.

// File: rtl/batt_link_pkg.sv
package batt_link_pkg;
  typedef enum logic {
    LINK_OFF = 1'b0,
    LINK_ON  = 1'b1
  } link_state_e;
endpackage

// File: rtl/batt_link_hold_timer.sv
module batt_link_hold_timer #(
  parameter int unsigned HOLD_TICKS = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = arm_i && tick_i && (cnt_q == LAST);

  // progress is lost whenever the request is not armed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!arm_i || done_o)  cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/batt_link_fsm.sv
module batt_link_fsm
  import batt_link_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_i,
  input  logic supply_ok_i,
  input  logic done_i,
  output logic conn_o
);
  link_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!supply_ok_i) begin
      if (!ctrl_i)     state_d = LINK_OFF;
      else if (done_i) state_d = LINK_ON;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LINK_OFF;
    else         state_q <= state_d;
  end

  assign conn_o = (state_q == LINK_ON);
endmodule

// File: rtl/batt_link_ctrl.sv
module batt_link_ctrl #(
  parameter int unsigned HOLD_TICKS = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_i,
  input  logic supply_ok_i,
  input  logic tick_i,
  output logic conn_o
);
  logic arm, done;

  // count only while a reconnect is actually pending
  assign arm = ctrl_i && !supply_ok_i && !conn_o;

  batt_link_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .tick_i (tick_i),
    .done_o (done)
  );

  batt_link_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl_i),
    .supply_ok_i (supply_ok_i),
    .done_i      (done),
    .conn_o      (conn_o)
  );
endmodule

// File: rtl/batt_link_ctrl_chk.sv
module batt_link_ctrl_chk #(
  parameter int unsigned HOLD_TICKS = 2000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ctrl_i,
  input logic supply_ok_i,
  input logic tick_i,
  input logic conn_o
);
  localparam int unsigned KW = $clog2(HOLD_TICKS + 2);
  localparam logic [KW-1:0] HOLD_K = KW'(HOLD_TICKS);

  // independent count of pulses in the current unbroken high run
  logic [KW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     run_q <= '0;
    else if (!ctrl_i || supply_ok_i) run_q <= '0;
    else if (tick_i && run_q != HOLD_K) run_q <= run_q + 1'b1;
  end

  a_r1_low_cuts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supply_ok_i && !ctrl_i) |=> !conn_o);

  a_r2_hold_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conn_o) |-> (run_q == HOLD_K));

  a_r8_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conn_o) |-> $past(tick_i && ctrl_i && !supply_ok_i));

  a_r4_stays_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conn_o && ctrl_i) |=> conn_o);

  a_r5_supply_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_ok_i |=> (conn_o == $past(conn_o)));

  always @(posedge clk_i) begin
    if (!rst_ni) a_r7_reset_off: assert (!conn_o);
  end
endmodule

bind batt_link_ctrl batt_link_ctrl_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_i      (ctrl_i),
  .supply_ok_i (supply_ok_i),
  .tick_i      (tick_i),
  .conn_o      (conn_o)
);

// File: tb/batt_link_ctrl_tb.sv
`timescale 1ns/1ps
module batt_link_ctrl_tb;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl = 1'b0, sup = 1'b0, tick = 1'b0;
  logic conn;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  batt_link_ctrl #(.HOLD_TICKS(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl),
    .supply_ok_i(sup), .tick_i(tick), .conn_o(conn)
  );

  task automatic chk(input string req, input logic exp);
    n_chk++;
    if (conn !== exp) begin
      n_fail++;
      $display("FAIL %s: conn_o=%b expected=%b at %0t", req, conn, exp, $time);
    end
  endtask

  // apply inputs for one clock edge, return after the edge at the falling edge
  task automatic cyc(input logic c, input logic s, input logic t);
    ctrl = c; sup = s; tick = t;
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input logic s);
    for (int i = 0; i < n; i++) cyc(1'b1, s, 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ctrl = 0; sup = 0; tick = 0;
    @(negedge clk);
    chk("R7 in reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R7 after reset", 1'b0);

    // R2 R8 sweep: run length and tick spacing
    for (int p = 1; p <= 3; p++) begin
      for (int l = 0; l <= HOLD + 1; l++) begin
        cyc(1'b0, 1'b0, 1'b0);
        chk("R1 clear before run", 1'b0);
        for (int k = 1; k <= l; k++) begin
          for (int g = 0; g < p - 1; g++) begin
            cyc(1'b1, 1'b0, 1'b0);
            chk("R8 idle cycle", (k - 1) >= HOLD);
          end
          cyc(1'b1, 1'b0, 1'b1);
          chk("R2 after tick", k >= HOLD);
        end
        cyc(1'b0, 1'b0, 1'b1);
        chk("R1 line low", 1'b0);
      end
    end

    // R8: high line, no ticks
    for (int i = 0; i < 3 * HOLD; i++) cyc(1'b1, 1'b0, 1'b0);
    chk("R8 no ticks", 1'b0);
    cyc(1'b0, 1'b0, 1'b0);

    // R3: interrupted run restarts
    ticks(HOLD - 1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    ticks(HOLD - 1, 1'b0);
    chk("R3 restarted run short", 1'b0);
    ticks(1, 1'b0);
    chk("R3 full run after restart", 1'b1);

    // R4: stays on with line high
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, i[0]);
    chk("R4 stays connected", 1'b1);
    cyc(1'b1, 1'b1, 1'b1);
    chk("R4 with supply", 1'b1);

    // R5: supply freezes a connected output
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1);
    chk("R5 low line ignored", 1'b1);
    // R6: removal honours low line at once
    cyc(1'b0, 1'b0, 1'b0);
    chk("R6 immediate cut", 1'b0);

    // R5: supply freezes a disconnected output
    ticks(2 * HOLD, 1'b1);
    chk("R5 high line ignored", 1'b0);
    // R5: progress cleared by supply
    ticks(HOLD - 1, 1'b0);
    cyc(1'b1, 1'b1, 1'b1);
    ticks(1, 1'b0);
    chk("R5 progress discarded", 1'b0);
    ticks(HOLD - 2, 1'b0);
    chk("R5 partial rerun", 1'b0);
    ticks(1, 1'b0);
    chk("R6 rerun connects", 1'b1);

    // R6: removal with high line keeps connection
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R6 high line keeps", 1'b1);

    // R7: reset while connected
    do_reset();
    chk("R7 reset from connected", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule